// File: doc/BRIEF.md
# Parallel Receive Enable-Framing Sampler

This block takes a parallel input bus, one sample per receive clock, and decides beat by beat which samples are frame data. It then marks where each frame ends. A qualifying enable decides which beats count. That enable is either one of the bus lines, picked at run time, or a software-controlled bit. Each captured beat leaves the block registered, together with a valid flag. An end-of-frame flag marks the close of the frame, and a second flag marks the case where a stall watchdog ended the frame.

The framing rule depends on the sampling mode.

- **Level mode:** data is accepted while the enable line sits at the chosen level.
- **Pulse mode:** single-beat pulses on the enable line open the frame and, for most submodes, close it. Twelve submodes choose the pulse polarity and whether the pulse beats themselves count as data.
- **Software mode:** data is accepted on every beat while a software enable is high.

A frame can also close once a configured byte count has been received. After one frame has ended, the block waits for the start input to be dropped and raised again before it samples another frame.

Top module: `prx_rx_sampler`

## Requirements
- R1: After reset all outputs are 0. While `cfg_start` is 0 no beat is accepted and no end flag is produced. A bus value that is stable around rising edge k leaves the block at the outputs after rising edge k+1.
- R2: In level mode (`cfg_mode`=0), a beat is accepted while the enable line is 1 when `cfg_level_low`=0, and while it is 0 when `cfg_level_low`=1.
- R3: In level mode with `cfg_eof_by_en`=1, the first non-active beat after the frame opened produces `out_eof`=1 with `out_valid`=0. Byte length is ignored in this case.
- R4: Byte-length ending is used in level mode with `cfg_eof_by_en`=0, in pulse submodes 4, 5, 10 and 11, and always in software mode. Each accepted beat adds DATA_W/8 bytes. The beat that brings the total to at least `cfg_byte_len` carries `out_eof`=1 together with `out_valid`=1. After any end flag, no beat is accepted until `cfg_start` has been 0.
- R5: Pulse mode (`cfg_mode`=1) uses submodes 0–3 with a pulse level of 1 and submodes 6–9 with a pulse level of 0. Within each group, the offset from the group base means: 0 = start and end pulse beats both data, 1 = start beat data and end beat not, 2 = end beat data and start beat not, 3 = neither. The second pulse ends the frame: it gives `out_eof`=1, with `out_valid` set only when that pulse beat counts as data. Beats between the two pulses are data.
- R6: Pulse submodes 4 and 10 open the frame on a pulse beat that counts as data. Submodes 5 and 11 open it on a pulse beat that does not count. The polarity is 1 for submodes 4 and 5 and 0 for submodes 10 and 11. The frame then ends by byte length, and later pulse beats are ordinary data.
- R7: Pulse submodes 12–15 and `cfg_mode`=3 never produce `out_valid` or `out_eof`.
- R8: In software mode (`cfg_mode`=2), every beat is accepted while both `cfg_start` and `cfg_sw_en` are 1. The bus lines play no part in qualifying the beats.
- R9: The enable is bus line number `cfg_en_line`.
- R10: Suppose a frame is open and `cfg_to_en`=1. When `cfg_to_thresh` consecutive beats pass with no beat accepted and no end flag, the last of them produces `out_eof`=1 and `out_err_eof`=1 with `out_valid`=0. With `cfg_to_en`=0 no error end is produced.
- R11: With `cfg_fall_edge`=0 the bus is captured on the rising clock edge. With `cfg_fall_edge`=1 it is captured on the preceding falling edge. Latency is the same in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start | input | 1 | Sampling enable; dropping it clears the frame |
| cfg_mode | input | 2 | 0 level, 1 pulse, 2 software, 3 unused |
| cfg_level_low | input | 1 | Level mode: accept while enable is low |
| cfg_pulse_sub | input | 4 | Pulse submode 0..11 |
| cfg_sw_en | input | 1 | Software-mode beat enable |
| cfg_en_line | input | 4 | Bus line used as external enable |
| cfg_eof_by_en | input | 1 | Level mode: end on enable release instead of length |
| cfg_byte_len | input | 16 | Frame length in bytes |
| cfg_to_en | input | 1 | Stall watchdog enable |
| cfg_to_thresh | input | 16 | Stall beats before an error end |
| cfg_fall_edge | input | 1 | Capture on the falling edge |
| din | input | 16 | Parallel input bus |
| out_data | output | 16 | Captured beat |
| out_valid | output | 1 | Beat is frame data |
| out_eof | output | 1 | Frame ends on this beat |
| out_err_eof | output | 1 | Frame ended by the stall watchdog |

## Verification
Level mode is driven with each polarity, so an inverted or missing polarity setting shows up. It is also driven with end-by-release and with end-by-length, which separates the two end sources. All twelve pulse submodes are sent the same pulse pattern: two pulses separated by two data beats. Because the pattern is identical, each submode's outcome distinguishes start inclusion, end inclusion, polarity, and pulse versus length ending. The tests also cover:

- a stalled frame, run once with the watchdog on and once with it off;
- software mode with the software enable toggled during the frame;
- the enable taken from a different bus line;
- a bus value that changes between the falling and the rising edge, which tells the two capture edges apart.

// File: rtl/prx_pkg.sv
package prx_pkg;

   typedef enum logic [1:0] {
      SMP_LEVEL = 2'd0,
      SMP_PULSE = 2'd1,
      SMP_SOFT  = 2'd2,
      SMP_RSVD  = 2'd3
   } smp_mode_e;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_OPEN = 2'd1,
      FS_DONE = 2'd2
   } frm_state_e;

   typedef struct packed {
      logic ok;         // submode in use
      logic neg;        // pulse level is 0
      logic start_inc;  // opening pulse beat is data
      logic end_inc;    // closing pulse beat is data
      logic len_end;    // close by byte count
   } pulse_cfg_t;

   function automatic pulse_cfg_t decode_sub(input logic [3:0] s);
      pulse_cfg_t r;
      logic [3:0] k;
      r = '0;
      k = 4'd0;
      if (s < 4'd12) begin
         r.ok        = 1'b1;
         r.neg       = (s >= 4'd6);
         k           = r.neg ? (s - 4'd6) : s;
         r.len_end   = (k >= 4'd4);
         r.start_inc = (k == 4'd0) || (k == 4'd1) || (k == 4'd4);
         r.end_inc   = (k == 4'd0) || (k == 4'd2);
      end
      return r;
   endfunction

endpackage

// File: rtl/prx_capture.sv
module prx_capture #(
   parameter int DATA_W    = 16,
   parameter bit FALL_PATH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_sel,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] beat
);

   logic [DATA_W-1:0] rise_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rise_q <= '0;
      else        rise_q <= din;
   end

   generate
      if (FALL_PATH) begin : g_fall
         logic [DATA_W-1:0] fall_q;
         logic [DATA_W-1:0] fall_r;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) fall_q <= '0;
            else        fall_q <= din;
         end
         // retime so both edges reach the framer in the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fall_r <= '0;
            else        fall_r <= fall_q;
         end
         assign beat = fall_sel ? fall_r : rise_q;
      end else begin : g_rise_only
         logic unused_sel;
         assign unused_sel = fall_sel;
         assign beat = rise_q;
      end
   endgenerate

endmodule

// File: rtl/prx_timeout.sv
module prx_timeout #(
   parameter int TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            open,
   input  logic            busy,
   input  logic            enable,
   input  logic [TO_W-1:0] thresh,
   output logic            hit
);

   logic [TO_W-1:0] cnt;
   logic [TO_W:0]   cnt_nx;

   assign cnt_nx = {1'b0, cnt} + {{TO_W{1'b0}}, 1'b1};
   assign hit    = open && enable && !busy && (cnt_nx >= {1'b0, thresh});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (!open || busy || !enable) cnt <= '0;
      else if (!hit)                     cnt <= cnt_nx[TO_W-1:0];
   end

endmodule

// File: rtl/prx_frame_ctl.sv
module prx_frame_ctl
   import prx_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LEN_W  = 16,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_start,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_level_low,
   input  logic [3:0]        cfg_pulse_sub,
   input  logic              cfg_sw_en,
   input  logic [SEL_W-1:0]  cfg_en_line,
   input  logic              cfg_eof_by_en,
   input  logic [LEN_W-1:0]  cfg_byte_len,
   input  logic [DATA_W-1:0] beat,
   input  logic              to_hit,
   output logic              frm_open,
   output logic              frm_busy,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_eof,
   output logic              out_err_eof
);

   localparam int BPB = DATA_W / 8;

   frm_state_e     state, nxt_norm, nxt;
   smp_mode_e      mode;
   pulse_cfg_t     sc;
   logic [LEN_W:0] bytes, bytes_nx;
   logic           en_bit, lvl_act, pulse, reach;
   logic           acc, end_norm, end_f, err_f;

   assign mode     = smp_mode_e'(cfg_mode);
   assign sc       = decode_sub(cfg_pulse_sub);
   assign en_bit   = beat[cfg_en_line];
   assign lvl_act  = en_bit ^ cfg_level_low;
   assign pulse    = en_bit ^ sc.neg;
   assign bytes_nx = bytes + (LEN_W + 1)'(BPB);
   assign reach    = (bytes_nx >= {1'b0, cfg_byte_len});

   // framing decision without the watchdog
   always_comb begin
      acc      = 1'b0;
      end_norm = 1'b0;
      nxt_norm = state;
      if (!cfg_start) begin
         nxt_norm = FS_IDLE;
      end else begin
         case (state)
            FS_IDLE: begin
               case (mode)
                  SMP_LEVEL: if (lvl_act) begin
                     acc      = 1'b1;
                     nxt_norm = FS_OPEN;
                     if (!cfg_eof_by_en && reach) begin
                        end_norm = 1'b1;
                        nxt_norm = FS_DONE;
                     end
                  end
                  SMP_PULSE: if (sc.ok && pulse) begin
                     acc      = sc.start_inc;
                     nxt_norm = FS_OPEN;
                     if (sc.len_end && sc.start_inc && reach) begin
                        end_norm = 1'b1;
                        nxt_norm = FS_DONE;
                     end
                  end
                  SMP_SOFT: if (cfg_sw_en) begin
                     acc      = 1'b1;
                     nxt_norm = FS_OPEN;
                     if (reach) begin
                        end_norm = 1'b1;
                        nxt_norm = FS_DONE;
                     end
                  end
                  default: ;
               endcase
            end
            FS_OPEN: begin
               case (mode)
                  SMP_LEVEL: begin
                     if (lvl_act) begin
                        acc = 1'b1;
                        if (!cfg_eof_by_en && reach) begin
                           end_norm = 1'b1;
                           nxt_norm = FS_DONE;
                        end
                     end else if (cfg_eof_by_en) begin
                        end_norm = 1'b1;
                        nxt_norm = FS_DONE;
                     end
                  end
                  SMP_PULSE: begin
                     if (!sc.ok) begin
                        acc = 1'b0;
                     end else if (sc.len_end) begin
                        acc = 1'b1;
                        if (reach) begin
                           end_norm = 1'b1;
                           nxt_norm = FS_DONE;
                        end
                     end else if (pulse) begin
                        acc      = sc.end_inc;
                        end_norm = 1'b1;
                        nxt_norm = FS_DONE;
                     end else begin
                        acc = 1'b1;
                     end
                  end
                  SMP_SOFT: if (cfg_sw_en) begin
                     acc = 1'b1;
                     if (reach) begin
                        end_norm = 1'b1;
                        nxt_norm = FS_DONE;
                     end
                  end
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end

   assign frm_open = (state == FS_OPEN);
   assign frm_busy = acc || end_norm;

   // merge the watchdog end
   always_comb begin
      nxt   = nxt_norm;
      end_f = end_norm;
      err_f = 1'b0;
      if (cfg_start && to_hit) begin
         nxt   = FS_DONE;
         end_f = 1'b1;
         err_f = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= FS_IDLE;
         bytes <= '0;
      end else begin
         state <= nxt;
         if (nxt != FS_OPEN)
            bytes <= '0;
         else if (acc)
            bytes <= (bytes_nx < bytes) ? bytes : bytes_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data    <= '0;
         out_valid   <= 1'b0;
         out_eof     <= 1'b0;
         out_err_eof <= 1'b0;
      end else begin
         out_data    <= beat;
         out_valid   <= acc;
         out_eof     <= end_f;
         out_err_eof <= err_f;
      end
   end

endmodule

// File: rtl/prx_rx_sampler.sv
module prx_rx_sampler #(
   parameter int DATA_W    = 16,
   parameter int LEN_W     = 16,
   parameter int TO_W      = 16,
   parameter bit FALL_PATH = 1'b1,
   localparam int SEL_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_start,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_level_low,
   input  logic [3:0]        cfg_pulse_sub,
   input  logic              cfg_sw_en,
   input  logic [SEL_W-1:0]  cfg_en_line,
   input  logic              cfg_eof_by_en,
   input  logic [LEN_W-1:0]  cfg_byte_len,
   input  logic              cfg_to_en,
   input  logic [TO_W-1:0]   cfg_to_thresh,
   input  logic              cfg_fall_edge,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_eof,
   output logic              out_err_eof
);

   generate
      if ((DATA_W < 8) || (DATA_W % 8 != 0)) begin : g_bad_width
         $error("prx_rx_sampler: DATA_W must be a nonzero multiple of 8");
      end
      if (LEN_W < 2 || TO_W < 2) begin : g_bad_cnt
         $error("prx_rx_sampler: LEN_W and TO_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] beat;
   logic              frm_open, frm_busy, to_hit;

   prx_capture #(.DATA_W(DATA_W), .FALL_PATH(FALL_PATH)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_sel (cfg_fall_edge),
      .din      (din),
      .beat     (beat)
   );

   prx_timeout #(.TO_W(TO_W)) u_to (
      .clk    (clk),
      .rst_n  (rst_n),
      .open   (frm_open),
      .busy   (frm_busy),
      .enable (cfg_to_en),
      .thresh (cfg_to_thresh),
      .hit    (to_hit)
   );

   prx_frame_ctl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SEL_W(SEL_W)) u_frm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_start     (cfg_start),
      .cfg_mode      (cfg_mode),
      .cfg_level_low (cfg_level_low),
      .cfg_pulse_sub (cfg_pulse_sub),
      .cfg_sw_en     (cfg_sw_en),
      .cfg_en_line   (cfg_en_line),
      .cfg_eof_by_en (cfg_eof_by_en),
      .cfg_byte_len  (cfg_byte_len),
      .beat          (beat),
      .to_hit        (to_hit),
      .frm_open      (frm_open),
      .frm_busy      (frm_busy),
      .out_data      (out_data),
      .out_valid     (out_valid),
      .out_eof       (out_eof),
      .out_err_eof   (out_err_eof)
   );

endmodule

// File: rtl/prx_rx_sampler_chk.sv
module prx_rx_sampler_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_start,
   input logic [1:0] cfg_mode,
   input logic       cfg_sw_en,
   input logic       out_valid,
   input logic       out_eof,
   input logic       out_err_eof
);

   a_r1_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_start |=> (!out_valid && !out_eof));

   a_r4_hold_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |=> !out_valid);

   a_r7_unused_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd3) |=> !out_valid);

   a_r8_soft_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd2 && !cfg_sw_en) |=> !out_valid);

   a_r10_err_is_end: assert property (@(posedge clk) disable iff (!rst_n)
      out_err_eof |-> (out_eof && !out_valid));

endmodule

bind prx_rx_sampler prx_rx_sampler_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_start   (cfg_start),
   .cfg_mode    (cfg_mode),
   .cfg_sw_en   (cfg_sw_en),
   .out_valid   (out_valid),
   .out_eof     (out_eof),
   .out_err_eof (out_err_eof)
);

// File: tb/sim_prx_rx_sampler.sv
module sim_prx_rx_sampler;

   localparam int PERIOD = 20;
   localparam int Q      = PERIOD / 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_start = 1'b0;
   logic [1:0]  cfg_mode = 2'd0;
   logic        cfg_level_low = 1'b0;
   logic [3:0]  cfg_pulse_sub = 4'd0;
   logic        cfg_sw_en = 1'b0;
   logic [3:0]  cfg_en_line = 4'd15;
   logic        cfg_eof_by_en = 1'b0;
   logic [15:0] cfg_byte_len = 16'd0;
   logic        cfg_to_en = 1'b1;
   logic [15:0] cfg_to_thresh = 16'd4095;
   logic        cfg_fall_edge = 1'b0;
   logic [15:0] din = 16'h0000;
   logic [15:0] out_data;
   logic        out_valid, out_eof, out_err_eof;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit run_start = 1'b1;

   logic [15:0] bd [16];
   logic        bs [16];
   logic        ev [16];
   logic        ee [16];
   logic        ex [16];

   always #(PERIOD/2) clk = ~clk;

   prx_rx_sampler u0 (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
      .cfg_level_low(cfg_level_low), .cfg_pulse_sub(cfg_pulse_sub),
      .cfg_sw_en(cfg_sw_en), .cfg_en_line(cfg_en_line),
      .cfg_eof_by_en(cfg_eof_by_en), .cfg_byte_len(cfg_byte_len),
      .cfg_to_en(cfg_to_en), .cfg_to_thresh(cfg_to_thresh),
      .cfg_fall_edge(cfg_fall_edge), .din(din), .out_data(out_data),
      .out_valid(out_valid), .out_eof(out_eof), .out_err_eof(out_err_eof)
   );

   task automatic step();
      @(posedge clk);
      #Q;
   endtask

   task automatic clear_exp();
      for (int i = 0; i < 16; i++) begin
         bd[i] = 16'h0000; bs[i] = 1'b0;
         ev[i] = 1'b0; ee[i] = 1'b0; ex[i] = 1'b0;
      end
   endtask

   task automatic check_beat(input string tag, input int j);
      n_chk++;
      if (out_valid !== ev[j] || out_eof !== ee[j] || out_err_eof !== ex[j] ||
          (ev[j] && out_data !== bd[j])) begin
         n_bad++;
         $display("FAIL %s beat %0d: got v=%b e=%b x=%b d=%h, expected v=%b e=%b x=%b d=%h",
                  tag, j, out_valid, out_eof, out_err_eof, out_data,
                  ev[j], ee[j], ex[j], bd[j]);
      end
   endtask

   // drive n beats; outputs for beat j are sampled two steps later
   task automatic run(input int n, input logic [15:0] idle, input string tag);
      din = idle; cfg_start = 1'b0; cfg_sw_en = 1'b0;
      repeat (2) step();
      for (int i = 0; i < n + 2; i++) begin
         step();
         if (i >= 2) check_beat(tag, i - 2);
         din = (i < n) ? bd[i] : idle;
         if (i >= 1) begin
            cfg_start = run_start;
            cfg_sw_en = (i - 1 < n) ? bs[i - 1] : 1'b0;
         end
      end
      cfg_start = 1'b0; cfg_sw_en = 1'b0; din = idle;
      repeat (3) step();
   endtask

   task automatic t_reset();
      n_chk++;
      if (out_valid !== 1'b0 || out_eof !== 1'b0 || out_err_eof !== 1'b0 || out_data !== 16'h0) begin
         n_bad++;
         $display("FAIL R1 reset: got v=%b e=%b x=%b d=%h, expected all 0",
                  out_valid, out_eof, out_err_eof, out_data);
      end
   endtask

   task automatic t_stopped();  // R1
      clear_exp();
      cfg_mode = 2'd0; cfg_level_low = 1'b0; cfg_eof_by_en = 1'b1;
      bd[0] = 16'h8001; bd[1] = 16'h8002; bd[2] = 16'h0003;
      run_start = 1'b0;
      run(3, 16'h0000, "R1 start low");
      run_start = 1'b1;
   endtask

   task automatic t_level_high();  // R2 R3
      clear_exp();
      cfg_mode = 2'd0; cfg_level_low = 1'b0; cfg_eof_by_en = 1'b1; cfg_byte_len = 16'd2;
      bd[0] = 16'h0001; bd[1] = 16'h8011; bd[2] = 16'h8022; bd[3] = 16'h0033; bd[4] = 16'h8044;
      ev[1] = 1'b1; ev[2] = 1'b1; ee[3] = 1'b1;
      run(5, 16'h0000, "R2 R3 level high");
   endtask

   task automatic t_level_low();  // R2 R3
      clear_exp();
      cfg_mode = 2'd0; cfg_level_low = 1'b1; cfg_eof_by_en = 1'b1;
      bd[0] = 16'h8001; bd[1] = 16'h0011; bd[2] = 16'h8022;
      ev[1] = 1'b1; ee[2] = 1'b1;
      run(3, 16'h8000, "R2 level low");
      cfg_level_low = 1'b0;
   endtask

   task automatic t_level_len();  // R4
      clear_exp();
      cfg_mode = 2'd0; cfg_eof_by_en = 1'b0; cfg_byte_len = 16'd5;
      bd[0] = 16'h8001; bd[1] = 16'h0002; bd[2] = 16'h8003; bd[3] = 16'h8004; bd[4] = 16'h8005;
      ev[0] = 1'b1; ev[2] = 1'b1; ev[3] = 1'b1; ee[3] = 1'b1;
      run(5, 16'h0000, "R4 level length");
   endtask

   task automatic t_soft();  // R8 R4
      clear_exp();
      cfg_mode = 2'd2; cfg_byte_len = 16'd6;
      bd[0] = 16'h1111; bd[1] = 16'h2222; bd[2] = 16'h0333; bd[3] = 16'h8444; bd[4] = 16'h5555;
      bs[0] = 1'b1; bs[1] = 1'b0; bs[2] = 1'b1; bs[3] = 1'b1; bs[4] = 1'b1;
      ev[0] = 1'b1; ev[2] = 1'b1; ev[3] = 1'b1; ee[3] = 1'b1;
      run(5, 16'h0000, "R8 software");
   endtask

   task automatic t_pulse(input logic [3:0] sub);  // R5 R6
      logic       neg, sin, ein, lend;
      logic [3:0] k;
      logic [15:0] p_val, q_val;
      string tag;
      clear_exp();
      neg   = (sub >= 4'd6);
      k     = neg ? sub - 4'd6 : sub;
      sin   = (k == 4'd0) || (k == 4'd1) || (k == 4'd4);
      ein   = (k == 4'd0) || (k == 4'd2);
      lend  = (k >= 4'd4);
      p_val = neg ? 16'h0000 : 16'h8000;
      q_val = neg ? 16'h8000 : 16'h0000;
      cfg_mode = 2'd1; cfg_pulse_sub = sub; cfg_byte_len = 16'd6;
      bd[0] = q_val | 16'h0100; bd[1] = p_val | 16'h0101; bd[2] = q_val | 16'h0102;
      bd[3] = q_val | 16'h0103; bd[4] = p_val | 16'h0104; bd[5] = q_val | 16'h0105;
      ev[1] = sin; ev[2] = 1'b1; ev[3] = 1'b1;
      if (lend) begin
         if (sin) ee[3] = 1'b1;
         else begin ev[4] = 1'b1; ee[4] = 1'b1; end
      end else begin
         ev[4] = ein; ee[4] = 1'b1;
      end
      tag = lend ? $sformatf("R6 pulse sub=%0d", sub) : $sformatf("R5 pulse sub=%0d", sub);
      run(6, q_val, tag);
   endtask

   task automatic t_reserved();  // R7
      clear_exp();
      cfg_mode = 2'd1; cfg_pulse_sub = 4'd12; cfg_byte_len = 16'd2;
      bd[0] = 16'h0001; bd[1] = 16'h8002; bd[2] = 16'h0003; bd[3] = 16'h8004;
      run(4, 16'h0000, "R7 submode 12");
      cfg_pulse_sub = 4'd15;
      run(4, 16'h0000, "R7 submode 15");
      cfg_mode = 2'd3; cfg_pulse_sub = 4'd0;
      run(4, 16'h0000, "R7 mode 3");
   endtask

   task automatic t_line_sel();  // R9
      clear_exp();
      cfg_mode = 2'd0; cfg_level_low = 1'b0; cfg_eof_by_en = 1'b1; cfg_en_line = 4'd3;
      bd[0] = 16'h8000; bd[1] = 16'h0008; bd[2] = 16'h8000;
      ev[1] = 1'b1; ee[2] = 1'b1;
      run(3, 16'h0000, "R9 line 3");
      cfg_en_line = 4'd15;
   endtask

   task automatic t_timeout(input logic on);  // R10
      clear_exp();
      cfg_mode = 2'd0; cfg_eof_by_en = 1'b0; cfg_byte_len = 16'd100;
      cfg_to_en = on; cfg_to_thresh = 16'd3;
      bd[0] = 16'h8001; bd[1] = 16'h0002; bd[2] = 16'h0003; bd[3] = 16'h0004; bd[4] = 16'h0005;
      ev[0] = 1'b1;
      if (on) begin ee[3] = 1'b1; ex[3] = 1'b1; end
      run(5, 16'h0000, on ? "R10 watchdog on" : "R10 watchdog off");
      cfg_to_en = 1'b1; cfg_to_thresh = 16'd4095;
   endtask

   task automatic t_edge(input logic fall);  // R11
      logic [15:0] exp_d;
      cfg_mode = 2'd0; cfg_level_low = 1'b0; cfg_eof_by_en = 1'b0; cfg_byte_len = 16'd100;
      cfg_fall_edge = fall; din = 16'h0000; cfg_start = 1'b0;
      repeat (2) step();
      step();
      cfg_start = 1'b1; din = 16'h8A01;
      #(2*Q);
      din = 16'h8B02;
      step();
      din = 16'h0000;
      step();
      exp_d = fall ? 16'h8A01 : 16'h8B02;
      n_chk++;
      if (out_valid !== 1'b1 || out_data !== exp_d) begin
         n_bad++;
         $display("FAIL R11 fall=%0b: got v=%b d=%h, expected v=1 d=%h",
                  fall, out_valid, out_data, exp_d);
      end
      cfg_start = 1'b0; cfg_fall_edge = 1'b0;
      repeat (3) step();
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #Q;
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_stopped();
      t_level_high();
      t_level_low();
      t_level_len();
      t_soft();
      for (int s = 0; s < 12; s++) t_pulse(4'(s));
      t_reserved();
      t_line_sel();
      t_timeout(1'b1);
      t_timeout(1'b0);
      t_edge(1'b0);
      t_edge(1'b1);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule